// File: doc/BRIEF.md
# Three-State Carry-Scan Adder

This block adds two unsigned W-bit operands and a carry-in and presents the W-bit sum and the carry-out from one output register. Carries do not ripple from bit to bit. Each bit position is first labelled with one of three carry states. A parallel prefix scan over those labels then resolves the carry into every position, and each sum bit is the exclusive-or of the two operand bits and that carry.

The labels are:
- **Kill**: both operand bits are 0. No carry leaves this position.
- **Make**: both operand bits are 1. A carry always leaves this position.
- **Pass**: the operand bits differ. The incoming carry is passed on.

The carry-in enters the scan as an extra position below bit 0. It is labelled Make or Kill, so every scanned prefix ends in a definite state. The scan combines two states with a rule that is not commutative. The upper state wins unless it is Pass, and in that case the lower state shows through. The scan has ceil(log2(W+1)) levels of combine cells. The sum and the carry-out are registered once, so a result appears one clock edge after its operands.

Top module: `carry_scan_adder`

## Requirements
- R1: At each rising clock edge with reset released, `sum` takes the value (a + b + cin) mod 2^W of the operands present before that edge.
- R2: At the same edge, `cout` takes bit W of the full (W+1)-bit total a + b + cin.
- R3: While `rst_n` is low, `sum` and `cout` are 0, and asserting `rst_n` low clears them without waiting for a clock edge.
- R4: When every bit position is Pass (b equals the bitwise inverse of a) and `cin` is 1, the next result is `sum` = 0 and `cout` = 1, because the carry-in reaches the top through all W positions.
- R5: When every bit position is Make (a and b are all ones), the next result is `sum` = all ones except bit 0, where bit 0 equals `cin`, and `cout` = 1.
- R6: When every bit position is Kill (a = b = 0), the next result is `sum` = `cin` in bit 0 and zeros elsewhere, and `cout` = 0.
- R7: The carry into any position is set by the nearest non-Pass position below it. A Make at bit 0 with Pass at every higher bit gives `cout` = 1 whatever the value of `cin`. A Kill at the top bit gives `cout` = 0 whatever lies below it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the result register captures on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset of the result register |
| a | input | WIDTH | First operand |
| b | input | WIDTH | Second operand |
| cin | input | 1 | Carry into bit 0 |
| sum | output | WIDTH | Registered sum, modulo 2^WIDTH |
| cout | output | 1 | Registered carry out of the top bit |

## Verification
Two things can land on the same clock edge.

The first pair is a carry-in that must travel the full length of an all-Pass operand pair, together with that same edge's capture of the sum. The bench provokes this by following an all-Pass pair at once with pairs that have a single Make or Kill at the bottom or the top. The scoreboard compares each registered result against a total formed by plain addition in the bench.

The second pair is an asynchronous reset that arrives while operands are still changing, against the capture of a new result. The bench drops reset in the middle of a clock period with non-zero outputs showing. It then requires `sum` and `cout` to read zero before the next edge, and to stay zero while reset is held.

// File: rtl/carry_scan_pkg.sv
package carry_scan_pkg;

    // Carry state of one bit position (or of a scanned span of positions).
    typedef enum logic [1:0] {
        CS_KILL = 2'b00,
        CS_PASS = 2'b01,
        CS_MAKE = 2'b11
    } cstate_e;

    // Label one position from its two operand bits.
    function automatic cstate_e classify(input logic x, input logic y);
        if (x ^ y)
            return CS_PASS;
        else if (x)
            return CS_MAKE;
        else
            return CS_KILL;
    endfunction

    // Merge an upper span with the span directly below it.
    // The upper state decides unless it is Pass, in which case the lower shows through.
    function automatic cstate_e merge(input cstate_e upper, input cstate_e lower);
        return (upper == CS_PASS) ? lower : upper;
    endfunction

endpackage

// File: rtl/cs_classify.sv
module cs_classify
    import carry_scan_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic             cin,
    output cstate_e          st [0:WIDTH]
);
    // Slot 0 holds the injected carry-in; slot i+1 holds operand bit i.
    assign st[0] = cin ? CS_MAKE : CS_KILL;

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        assign st[i+1] = classify(a[i], b[i]);
    end
endmodule

// File: rtl/cs_prefix_scan.sv
module cs_prefix_scan
    import carry_scan_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  cstate_e          st    [0:WIDTH],
    output logic [WIDTH:0]   carry
);
    localparam int SLOTS  = WIDTH + 1;
    localparam int LEVELS = (SLOTS > 1) ? $clog2(SLOTS) : 1;

    cstate_e lvl [0:LEVELS][0:WIDTH];

    for (genvar j = 0; j < SLOTS; j++) begin : g_in
        assign lvl[0][j] = st[j];
    end

    // One level per power-of-two distance; slots below the distance are already final.
    for (genvar l = 0; l < LEVELS; l++) begin : g_lvl
        localparam int DIST = 1 << l;
        for (genvar j = 0; j < SLOTS; j++) begin : g_slot
            if (j >= DIST) begin : g_cell
                assign lvl[l+1][j] = merge(lvl[l][j], lvl[l][j-DIST]);
            end else begin : g_wire
                assign lvl[l+1][j] = lvl[l][j];
            end
        end
    end

    // Slot 0 is never Pass, so every full prefix resolves to Make or Kill.
    // carry[i] is the carry into bit i; carry[WIDTH] leaves the top bit.
    for (genvar j = 0; j < SLOTS; j++) begin : g_out
        assign carry[j] = (lvl[LEVELS][j] == CS_MAKE);
    end
endmodule

// File: rtl/cs_sum_xor.sv
module cs_sum_xor #(
    parameter int WIDTH = 16
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic [WIDTH-1:0] cy,
    output logic [WIDTH-1:0] s
);
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        assign s[i] = a[i] ^ b[i] ^ cy[i];
    end
endmodule

// File: rtl/carry_scan_adder.sv
module carry_scan_adder
    import carry_scan_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic             cin,
    output logic [WIDTH-1:0] sum,
    output logic             cout
);
    typedef struct packed {
        logic [WIDTH-1:0] sum;
        logic             cout;
    } result_t;

    cstate_e          st [0:WIDTH];
    logic [WIDTH:0]   carry;
    logic [WIDTH-1:0] sum_bits;
    result_t          res_d;
    result_t          res_q;

    cs_classify #(.WIDTH(WIDTH)) u_classify (
        .a   (a),
        .b   (b),
        .cin (cin),
        .st  (st)
    );

    cs_prefix_scan #(.WIDTH(WIDTH)) u_scan (
        .st    (st),
        .carry (carry)
    );

    cs_sum_xor #(.WIDTH(WIDTH)) u_sum (
        .a  (a),
        .b  (b),
        .cy (carry[WIDTH-1:0]),
        .s  (sum_bits)
    );

    always_comb begin
        res_d      = res_q;
        res_d.sum  = sum_bits;
        res_d.cout = carry[WIDTH];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            res_q <= '0;
        else
            res_q <= res_d;
    end

    assign sum  = res_q.sum;
    assign cout = res_q.cout;
endmodule

// File: rtl/carry_scan_adder_chk.sv
module carry_scan_adder_chk #(
    parameter int WIDTH = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic [WIDTH-1:0] a,
    input logic [WIDTH-1:0] b,
    input logic             cin,
    input logic [WIDTH-1:0] sum,
    input logic             cout
);
    logic [WIDTH:0] total;
    assign total = {1'b0, a} + {1'b0, b} + {{WIDTH{1'b0}}, cin};

    // R1
    sum_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> sum == $past(total[WIDTH-1:0]));

    // R2
    carry_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> cout == $past(total[WIDTH]));

    // R3
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |-> (sum == '0 && !cout));

    // R4
    full_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && a == ~b && cin) |=> (sum == '0 && cout));

    // R5
    all_make_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && &a && &b) |=> (cout && sum[WIDTH-1:1] == {(WIDTH-1){1'b1}}
                                 && sum[0] == $past(cin)));

    // R6
    all_kill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && a == '0 && b == '0) |=> (!cout && sum[WIDTH-1:1] == '0
                                           && sum[0] == $past(cin)));

    // R7
    top_kill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && !a[WIDTH-1] && !b[WIDTH-1]) |=> !cout);
endmodule

bind carry_scan_adder carry_scan_adder_chk #(.WIDTH(WIDTH)) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .a     (a),
    .b     (b),
    .cin   (cin),
    .sum   (sum),
    .cout  (cout)
);

// File: tb/tb_carry_scan_adder.sv
module tb_carry_scan_adder;
    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst_n = 1'b1;
    logic [W-1:0] a = '0;
    logic [W-1:0] b = '0;
    logic         cin = 1'b0;
    logic [W-1:0] sum;
    logic         cout;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [W:0] exp_q [$];
    string      tag_q [$];

    always #4 clk = ~clk;   // 125 MHz

    carry_scan_adder #(.WIDTH(W)) dut (
        .clk(clk), .rst_n(rst_n), .a(a), .b(b), .cin(cin), .sum(sum), .cout(cout)
    );

    task automatic check(input string tag, input logic [W:0] got, input logic [W:0] want);
        checks++;
        if (got !== want) begin
            errors++;
            $display("FAIL %s: got cout=%0b sum=%h, expected cout=%0b sum=%h",
                     tag, got[W], got[W-1:0], want[W], want[W-1:0]);
        end
    endtask

    // Driver: apply operands after a falling edge and queue the expected total.
    task automatic drive(input logic [W-1:0] x, input logic [W-1:0] y, input logic c,
                         input string tag);
        @(negedge clk);
        a   = x;
        b   = y;
        cin = c;
        exp_q.push_back({1'b0, x} + {1'b0, y} + {{W{1'b0}}, c});
        tag_q.push_back(tag);
    endtask

    // Monitor: just after each rising edge, compare the result with the oldest queued item.
    always @(posedge clk) begin
        #1;
        if (rst_n && exp_q.size() > 0) begin
            logic [W:0] want;
            string      t;
            want = exp_q.pop_front();
            t    = tag_q.pop_front();
            check(t, {cout, sum}, want);
        end
    end

    task automatic drain;
        while (exp_q.size() > 0) @(posedge clk);
        #2;
    endtask

    initial begin
        #1 rst_n = 1'b0;
        repeat (2) @(negedge clk);
        check("R3 reset", {cout, sum}, '0);
        @(negedge clk);
        rst_n = 1'b1;

        drive(16'h1234, 16'h0F0F, 1'b0, "R1 mixed");
        drive(16'hFFFF, 16'h0001, 1'b0, "R2 wrap");
        drive(16'hA5A5, ~16'hA5A5, 1'b1, "R4 all pass cin");
        drive(16'hA5A5, ~16'hA5A5, 1'b0, "R1 all pass no cin");
        drive(16'hFFFF, 16'hFFFF, 1'b0, "R5 all make");
        drive(16'hFFFF, 16'hFFFF, 1'b1, "R5 all make cin");
        drive(16'h0000, 16'h0000, 1'b1, "R6 all kill cin");
        drive(16'h0000, 16'h0000, 1'b0, "R6 all kill");
        drive(16'hFFFF, 16'h0001, 1'b1, "R7 make at bit0 cin");
        drive(16'h7FFF, 16'h0001, 1'b1, "R7 kill at top");
        drive(16'h8000, 16'h8000, 1'b0, "R2 make at top");
        drive(16'h00FF, 16'hFF00, 1'b1, "R4 pass run");
        for (int i = 0; i < 40; i++) begin
            drive(W'($urandom), W'($urandom), 1'($urandom), "R1 random");
        end
        drain();

        // Reset in mid-period while outputs are non-zero.
        drive(16'hF0F0, 16'h0F0F, 1'b0, "R1 before reset");
        drain();
        @(negedge clk);
        a = 16'h1357; b = 16'h2468;
        #1 rst_n = 1'b0;
        #1 check("R3 async clear", {cout, sum}, '0);
        @(negedge clk);
        check("R3 held", {cout, sum}, '0);
        rst_n = 1'b1;
        drive(16'h8001, 16'h8001, 1'b1, "R2 after reset");
        drain();

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #800000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule